// File: doc/BRIEF.md
# Command-Coded I2C Configuration Target

This block is an I2C target that gives a bus master access to a small bank of configuration registers. Every transaction that changes something starts with a write frame. The first byte after the target's address is a command byte, and its two low bits pick one of four operations: write registers, set the read pointer, save the bank to non-volatile storage, or restore it from storage. Read frames, where the address byte carries the read bit, return register contents starting at an internal pointer. That pointer always sits just after the register that was last accessed. A master can move the pointer with a read-command write frame and then use a repeated START to go straight into the read frame.

The register bank itself sits outside the block and is reached through a simple port. The block supplies an address and a write-enable pulse with data, and the bank returns read data combinationally for the current address. Save and restore are not carried out here. The block raises a one-cycle request to an external sequencer when the STOP arrives. While that sequencer reports busy, the target does not acknowledge its own address. SCL and SDA pass through a synchronizer into the system clock domain. The target pulls SDA low only for its acknowledge bits and for the zero bits of the data it sends.

Top module: `cfg_i2c_target`

## Requirements
- R1: An address byte whose upper seven bits equal DEV_ADDR is acknowledged (SDA low during the ninth clock). A non-matching address is not acknowledged, and every later byte is ignored until the next START.
- R2: The command byte (first byte after an address with bit 0 = 0) is always acknowledged. Bits [1:0] select the operation: 00 write, 01 set pointer, 10 save, 11 restore. Bits [7:2] have no effect.
- R3: For command 00, the next byte sets the pointer, and each following byte is acknowledged and written to the pointed register with a one-cycle reg_we pulse. The pointer then increments, wrapping from the last register to register 0.
- R4: For command 01, the next byte sets the pointer and any further byte in that frame is not acknowledged and writes nothing. A read frame (address bit 0 = 1) returns registers starting at the pointer, MSB first, and increments the pointer after each byte it loads.
- R5: A repeated START after the pointer byte starts a new address phase directly, so a read frame can follow without a STOP.
- R6: A master NACK ends the read; SDA is released. A later read frame continues at the register after the last byte sent.
- R7: Commands 10 and 11 produce exactly one one-cycle save_req or restore_req at the following STOP. Extra bytes in that frame are not acknowledged. A repeated START before the STOP cancels the request. The two requests are never high together.
- R8: While busy_i is high, the target's own address is not acknowledged.
- R9: A START or STOP inside a byte abandons the frame and the partial byte writes nothing.
- R10: After reset, and after every STOP, sda_oe, reg_we, save_req and restore_req are low. sda_oe changes only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, also used to sample the bus |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | I2C clock line as seen at the pad |
| sda_i | input | 1 | I2C data line as seen at the pad |
| sda_oe | output | 1 | High pulls SDA low (open drain) |
| busy_i | input | 1 | Non-volatile sequencer busy; address is not acknowledged |
| reg_addr | output | ADDR_W | Register bank address (current pointer) |
| reg_wdata | output | 8 | Write data for the register bank |
| reg_we | output | 1 | One-cycle register write strobe |
| reg_rdata | input | 8 | Register bank read data for reg_addr |
| save_req | output | 1 | One-cycle request to save the bank |
| restore_req | output | 1 | One-cycle request to restore the bank |

## Verification
The properties assume a well-formed bus. The master changes SDA only while SCL is low, except when it makes a START or STOP, and it never makes a START or STOP while the target holds SDA low. SCL phases are also assumed to last several system clocks, so each SCL edge appears as one isolated edge after the synchronizer. The bench master keeps each SCL half-period at twelve system clocks and moves SDA only a quarter-bit after a falling SCL edge. It issues mid-byte STARTs and STOPs only while SDA is released, so every abort case it exercises stays inside those assumptions.

// File: rtl/cfg_i2c_pkg.sv
// Shared types for the command-coded I2C configuration target.
// Assumes: nothing beyond IEEE 1800-2017 enums.
package cfg_i2c_pkg;

    // Bit-level position of the target inside a frame
    typedef enum logic [2:0] {
        ST_IDLE,    // not addressed, SDA released
        ST_RX,      // shifting a byte in from the master
        ST_RX_ACK,  // driving the acknowledge for a received byte
        ST_TX,      // shifting a byte out to the master
        ST_TX_ACK   // waiting for the master acknowledge
    } bus_state_t;

    // Meaning of the next byte received in a write frame
    typedef enum logic [1:0] {
        ROLE_ADDR,
        ROLE_CMD,
        ROLE_REG,
        ROLE_DATA
    } rx_role_t;

    // Operation selected by the two low bits of the command byte
    typedef enum logic [1:0] {
        OP_WRITE   = 2'b00,
        OP_POINT   = 2'b01,
        OP_SAVE    = 2'b10,
        OP_RESTORE = 2'b11
    } op_t;

endpackage

// File: rtl/cfg_i2c_line_sync.sv
// Brings SCL and SDA into the clock domain and flags bus events.
// Assumes: each SCL/SDA level lasts several clk cycles, so one edge gives
// one event. Lines reset to the idle (high) level.
module cfg_i2c_line_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    localparam int DEPTH = SYNC_STAGES + 1;
    localparam int LINES = 2;

    logic [LINES-1:0]            line_in;
    logic [LINES-1:0][DEPTH-1:0] pipe;
    logic                        scl_p;
    logic                        sda_p;

    assign line_in = {sda_i, scl_i};

    // One shift chain per bus line: SYNC_STAGES flops plus a history flop
    for (genvar g = 0; g < LINES; g++) begin : g_line
        always_ff @(posedge clk) begin
            if (!rst_n) pipe[g] <= '1;
            else        pipe[g] <= {pipe[g][DEPTH-2:0], line_in[g]};
        end
    end

    assign scl_s = pipe[0][DEPTH-2];
    assign scl_p = pipe[0][DEPTH-1];
    assign sda_s = pipe[1][DEPTH-2];
    assign sda_p = pipe[1][DEPTH-1];

    // Edge and condition decode on the synchronized samples
    always_comb begin
        scl_rise  = scl_s & ~scl_p;
        scl_fall  = ~scl_s & scl_p;
        start_det = scl_s & scl_p & sda_p & ~sda_s;
        stop_det  = scl_s & scl_p & ~sda_p & sda_s;
    end
endmodule

// File: rtl/cfg_i2c_shifter.sv
// Byte shift register with bit counter, shared by receive and transmit.
// Assumes: shift is asserted once per SCL rise; the bit to transmit is
// always data_q[MSB], since each rise shifts the next bit up.
module cfg_i2c_shifter #(
    parameter int BYTE_W = 8,
    parameter int CNT_W  = $clog2(BYTE_W + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              load,
    input  logic [BYTE_W-1:0] load_val,
    input  logic              shift,
    input  logic              bit_in,
    output logic [BYTE_W-1:0] data_q,
    output logic [CNT_W-1:0]  cnt_q
);
    // Load wins over clear, clear over shift
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q <= '0;
            cnt_q  <= '0;
        end else if (load) begin
            data_q <= load_val;
            cnt_q  <= '0;
        end else if (clr) begin
            cnt_q  <= '0;
        end else if (shift) begin
            data_q <= {data_q[BYTE_W-2:0], bit_in};
            cnt_q  <= cnt_q + CNT_W'(1);
        end
    end
endmodule

// File: rtl/cfg_i2c_ptr.sv
// Register pointer: loaded from the bus, stepped after each access.
// Assumes: the bank has 2**ADDR_W entries, so wrap is the natural carry.
module cfg_i2c_ptr #(
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              set,
    input  logic [ADDR_W-1:0] set_val,
    input  logic              inc,
    output logic [ADDR_W-1:0] ptr_q
);
    // Set has priority over increment
    always_ff @(posedge clk) begin
        if (!rst_n)   ptr_q <= '0;
        else if (set) ptr_q <= set_val;
        else if (inc) ptr_q <= ptr_q + ADDR_W'(1);
    end
endmodule

// File: rtl/cfg_i2c_target.sv
// I2C target with command-coded access to an external register bank.
// Receives on SCL rise, changes SDA after SCL fall. START/STOP anywhere
// abandon the frame; save/restore requests are issued at STOP.
// Assumes: bank read data is combinational for reg_addr; bank size is a
// power of two; no clock stretching.
module cfg_i2c_target
    import cfg_i2c_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR    = 7'h5C,
    parameter int         ADDR_W      = 4,
    parameter int         SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_oe,
    input  logic              busy_i,
    output logic [ADDR_W-1:0] reg_addr,
    output logic [7:0]        reg_wdata,
    output logic              reg_we,
    input  logic [7:0]        reg_rdata,
    output logic              save_req,
    output logic              restore_req
);
    localparam int BYTE_W = 8;
    localparam int CNT_W  = $clog2(BYTE_W + 1);

    logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;

    bus_state_t        state;
    rx_role_t          role;
    op_t               op;
    logic              ack_pend;
    logic              next_tx;
    logic              mack;
    logic              save_pend;
    logic              restore_pend;

    logic [BYTE_W-1:0] sh_q;
    logic [CNT_W-1:0]  cnt_q;
    logic              sh_shift, sh_clr, sh_load;
    logic [BYTE_W-1:0] rx_byte;
    logic              byte_done;
    logic              ptr_set, ptr_inc;
    logic [ADDR_W-1:0] ptr_q;

    cfg_i2c_line_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .scl_s     (scl_s),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    cfg_i2c_shifter #(.BYTE_W(BYTE_W), .CNT_W(CNT_W)) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (sh_clr),
        .load     (sh_load),
        .load_val (reg_rdata),
        .shift    (sh_shift),
        .bit_in   (sda_s),
        .data_q   (sh_q),
        .cnt_q    (cnt_q)
    );

    cfg_i2c_ptr #(.ADDR_W(ADDR_W)) u_ptr (
        .clk     (clk),
        .rst_n   (rst_n),
        .set     (ptr_set),
        .set_val (rx_byte[ADDR_W-1:0]),
        .inc     (ptr_inc),
        .ptr_q   (ptr_q)
    );

    assign reg_addr = ptr_q;

    // Shifter, pointer and byte-complete controls for this cycle
    always_comb begin
        rx_byte   = {sh_q[BYTE_W-2:0], sda_s};
        byte_done = (state == ST_RX) && scl_rise && !start_det && !stop_det
                    && (cnt_q == CNT_W'(BYTE_W - 1));
        sh_shift  = scl_rise && ((state == ST_RX) || (state == ST_TX));
        sh_clr    = start_det || ((state == ST_RX_ACK) && scl_fall && !next_tx);
        sh_load   = !start_det && !stop_det && scl_fall &&
                    (((state == ST_RX_ACK) && next_tx) ||
                     ((state == ST_TX_ACK) && !mack));
        ptr_set   = byte_done && (role == ROLE_REG);
        ptr_inc   = reg_we || sh_load;
    end

    // Frame sequencer: bus conditions first, then bit-phase handling
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state        <= ST_IDLE;
            role         <= ROLE_ADDR;
            op           <= OP_WRITE;
            ack_pend     <= 1'b0;
            next_tx      <= 1'b0;
            mack         <= 1'b1;
            sda_oe       <= 1'b0;
            reg_we       <= 1'b0;
            reg_wdata    <= '0;
            save_pend    <= 1'b0;
            restore_pend <= 1'b0;
            save_req     <= 1'b0;
            restore_req  <= 1'b0;
        end else begin
            reg_we      <= 1'b0;
            save_req    <= 1'b0;
            restore_req <= 1'b0;
            if (start_det) begin
                state        <= ST_RX;
                role         <= ROLE_ADDR;
                sda_oe       <= 1'b0;
                save_pend    <= 1'b0;
                restore_pend <= 1'b0;
            end else if (stop_det) begin
                state        <= ST_IDLE;
                role         <= ROLE_ADDR;
                sda_oe       <= 1'b0;
                save_req     <= save_pend;
                restore_req  <= restore_pend;
                save_pend    <= 1'b0;
                restore_pend <= 1'b0;
            end else begin
                case (state)
                    ST_RX: begin
                        if (byte_done) begin
                            next_tx <= 1'b0;
                            case (role)
                                ROLE_ADDR: begin
                                    if ((rx_byte[7:1] == DEV_ADDR) && !busy_i) begin
                                        ack_pend <= 1'b1;
                                        next_tx  <= rx_byte[0];
                                        role     <= ROLE_CMD;
                                    end else begin
                                        ack_pend <= 1'b0;
                                    end
                                end
                                ROLE_CMD: begin
                                    ack_pend     <= 1'b1;
                                    op           <= op_t'(rx_byte[1:0]);
                                    role         <= rx_byte[1] ? ROLE_DATA : ROLE_REG;
                                    save_pend    <= (rx_byte[1:0] == OP_SAVE);
                                    restore_pend <= (rx_byte[1:0] == OP_RESTORE);
                                end
                                ROLE_REG: begin
                                    ack_pend <= 1'b1;
                                    role     <= ROLE_DATA;
                                end
                                default: begin
                                    if (op == OP_WRITE) begin
                                        ack_pend  <= 1'b1;
                                        reg_we    <= 1'b1;
                                        reg_wdata <= rx_byte;
                                    end else begin
                                        ack_pend  <= 1'b0;
                                    end
                                end
                            endcase
                        end else if (scl_fall && (cnt_q == CNT_W'(BYTE_W))) begin
                            sda_oe <= ack_pend;
                            state  <= ack_pend ? ST_RX_ACK : ST_IDLE;
                        end
                    end
                    ST_RX_ACK: begin
                        if (scl_fall) begin
                            sda_oe <= next_tx ? ~reg_rdata[7] : 1'b0;
                            state  <= next_tx ? ST_TX : ST_RX;
                        end
                    end
                    ST_TX: begin
                        if (scl_fall) begin
                            if (cnt_q == CNT_W'(BYTE_W)) begin
                                sda_oe <= 1'b0;
                                state  <= ST_TX_ACK;
                            end else begin
                                sda_oe <= ~sh_q[BYTE_W-1];
                            end
                        end
                    end
                    ST_TX_ACK: begin
                        if (scl_rise) mack <= sda_s;
                        if (scl_fall) begin
                            sda_oe <= mack ? 1'b0 : ~reg_rdata[7];
                            state  <= mack ? ST_IDLE : ST_TX;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/cfg_i2c_checker.sv
// Protocol properties of cfg_i2c_target, attached with bind.
// Assumes: the well-formed bus described in the brief.
module cfg_i2c_checker #(
    parameter int ADDR_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              scl_s,
    input logic              start_det,
    input logic              stop_det,
    input logic              sda_oe,
    input logic              reg_we,
    input logic [ADDR_W-1:0] reg_addr,
    input logic              save_req,
    input logic              restore_req
);
    // Never both non-volatile requests at once
    assert_req_exclusive_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(save_req && restore_req));

    // Requests only follow a STOP condition
    assert_req_after_stop_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (save_req || restore_req) |-> $past(stop_det));

    // Each request is a single-cycle pulse
    assert_save_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        save_req |=> !save_req);

    assert_restore_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        restore_req |=> !restore_req);

    // A register write steps the pointer by one, with wrap
    assert_ptr_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we |=> (reg_addr == $past(reg_addr) + ADDR_W'(1)));

    // SDA drive changes only while the synchronized SCL was low
    assert_sda_on_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (sda_oe != $past(sda_oe)) |-> !$past(scl_s));

    // STOP always leaves SDA released
    assert_stop_release_R10: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> !sda_oe);

    // A START never coincides with a register write
    assert_start_no_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |=> !reg_we);
endmodule

bind cfg_i2c_target cfg_i2c_checker #(.ADDR_W(ADDR_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .scl_s       (scl_s),
    .start_det   (start_det),
    .stop_det    (stop_det),
    .sda_oe      (sda_oe),
    .reg_we      (reg_we),
    .reg_addr    (reg_addr),
    .save_req    (save_req),
    .restore_req (restore_req)
);

// File: tb/test_cfg_i2c_target.sv
`timescale 1ns/1ps
module test_cfg_i2c_target;
    localparam logic [6:0] DEV = 7'h5C;
    localparam int AW   = 4;
    localparam int NREG = 1 << AW;
    localparam int Q    = 6;
    localparam logic [7:0] AWR = {DEV, 1'b0};
    localparam logic [7:0] ARD = {DEV, 1'b1};

    // {command, register, data}
    localparam logic [23:0] VEC [6] = '{
        {8'h00, 8'h03, 8'hA5},
        {8'hFC, 8'h07, 8'h3C},
        {8'h54, 8'h0F, 8'hFF},
        {8'hA8, 8'h00, 8'h00},
        {8'h04, 8'h09, 8'h81},
        {8'h7C, 8'h0C, 8'h5A}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic m_scl = 1'b1;
    logic m_sda = 1'b1;
    logic busy_i = 1'b0;
    logic sda_oe, reg_we, save_req, restore_req;
    logic [AW-1:0] reg_addr;
    logic [7:0] reg_wdata, reg_rdata;
    logic sda_line;
    logic [7:0] bank [NREG];
    logic [7:0] model [NREG];
    int n_chk = 0;
    int n_fail = 0;
    int we_cnt = 0;
    int save_cnt = 0;
    int rest_cnt = 0;

    always #2 clk = ~clk;

    assign sda_line  = m_sda & ~sda_oe;
    assign reg_rdata = bank[reg_addr];

    cfg_i2c_target #(.DEV_ADDR(DEV), .ADDR_W(AW), .SYNC_STAGES(2)) i_cfg_i2c_target (
        .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_line), .sda_oe(sda_oe),
        .busy_i(busy_i), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_we(reg_we),
        .reg_rdata(reg_rdata), .save_req(save_req), .restore_req(restore_req)
    );

    function automatic logic [7:0] init_val(input int i);
        return 8'((i * 29) ^ 8'hC3);
    endfunction

    // Bench register bank and strobe counters
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++) bank[i] <= init_val(i);
        end else begin
            if (reg_we) begin
                bank[reg_addr] <= reg_wdata;
                we_cnt <= we_cnt + 1;
            end
            if (save_req) save_cnt <= save_cnt + 1;
            if (restore_req) rest_cnt <= rest_cnt + 1;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    task automatic wq(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic m_start();
        m_sda = 1'b1; wq(Q); m_scl = 1'b1; wq(Q); m_sda = 1'b0; wq(Q); m_scl = 1'b0; wq(Q);
    endtask

    task automatic m_stop();
        m_sda = 1'b0; wq(Q); m_scl = 1'b1; wq(Q); m_sda = 1'b1; wq(Q);
    endtask

    task automatic send_bits(input logic [7:0] b, input int n);
        for (int i = 7; i > 7 - n; i--) begin
            m_sda = b[i]; wq(Q); m_scl = 1'b1; wq(2 * Q); m_scl = 1'b0; wq(Q);
        end
    endtask

    task automatic send(input logic [7:0] b, output logic ack);
        send_bits(b, 8);
        m_sda = 1'b1; wq(Q); m_scl = 1'b1; wq(Q);
        ack = !sda_line;
        wq(Q); m_scl = 1'b0; wq(Q);
    endtask

    task automatic recv(input logic do_ack, output logic [7:0] b);
        m_sda = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            wq(Q); m_scl = 1'b1; wq(Q); b[i] = sda_line; wq(Q); m_scl = 1'b0; wq(Q);
        end
        m_sda = do_ack ? 1'b0 : 1'b1;
        wq(Q); m_scl = 1'b1; wq(2 * Q); m_scl = 1'b0; wq(Q);
        m_sda = 1'b1;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
        summary();
    end

    initial begin
        logic a0, a1, a2, a3, a4;
        logic [7:0] got, c, r, d;
        int base;
        for (int i = 0; i < NREG; i++) model[i] = init_val(i);
        wq(5);
        rst_n = 1'b1;
        wq(3);
        // R10: reset state
        check(sda_oe == 1'b0, "R10 sda_oe", sda_oe, 0);
        check(reg_we == 1'b0, "R10 reg_we", reg_we, 0);
        check(save_req == 1'b0, "R10 save_req", save_req, 0);
        check(restore_req == 1'b0, "R10 restore_req", restore_req, 0);

        // Vector table: write one register, then point at it and read back
        for (int k = 0; k < 6; k++) begin
            {c, r, d} = VEC[k];
            m_start(); send(AWR, a0); send(c, a1); send(r, a2); send(d, a3); m_stop();
            model[r[AW-1:0]] = d;
            check(a0 && a1 && a2 && a3, "R1 R2 R3 write acks", {a0, a1, a2, a3}, 4'hF);
            m_start(); send(AWR, a0); send({~c[7:2], 2'b01}, a1); send(r, a2);
            m_start(); send(ARD, a3); recv(1'b0, got); m_stop();
            check(a0 && a1 && a2 && a3, "R4 R5 pointer acks", {a0, a1, a2, a3}, 4'hF);
            check(got == d, "R2 R5 readback", got, d);
        end

        // R1: foreign address is ignored along with the rest of the frame
        base = we_cnt;
        m_start(); send({7'h22, 1'b0}, a0); send(8'h00, a1); send(8'h04, a2); m_stop();
        check(!a0, "R1 foreign address nack", a0, 0);
        check(!a1 && !a2, "R1 later bytes ignored", {a1, a2}, 0);
        check(we_cnt == base, "R1 no write", we_cnt, base);

        // R3: burst with wrap 14,15,0
        base = we_cnt;
        m_start(); send(AWR, a0); send(8'h00, a1); send(8'h0E, a2);
        send(8'h11, a3); send(8'h22, a4); send(8'h33, a0); m_stop();
        model[14] = 8'h11; model[15] = 8'h22; model[0] = 8'h33;
        check(a3 && a4 && a0, "R3 data acks", {a3, a4, a0}, 3'h7);
        check(we_cnt == base + 3, "R3 write count", we_cnt, base + 3);
        check(bank[14] == 8'h11 && bank[15] == 8'h22 && bank[0] == 8'h33,
              "R3 wrap contents", bank[0], 8'h33);

        // R4 R6: read continues after the last written register
        m_start(); send(ARD, a0); recv(1'b1, got);
        check(got == model[1], "R4 continue read", got, model[1]);
        recv(1'b0, got); m_stop();
        check(got == model[2], "R6 second byte", got, model[2]);
        check(sda_oe == 1'b0, "R6 released after nack", sda_oe, 0);
        m_start(); send(ARD, a0); recv(1'b0, got); m_stop();
        check(got == model[3], "R6 next frame continues", got, model[3]);

        // R4: pointer command refuses data bytes
        base = we_cnt;
        m_start(); send(AWR, a0); send(8'h01, a1); send(8'h0A, a2); send(8'h99, a3); m_stop();
        check(!a3, "R4 extra byte nack", a3, 0);
        check(we_cnt == base, "R4 no write", we_cnt, base);
        m_start(); send(ARD, a0); recv(1'b0, got); m_stop();
        check(got == model[10], "R4 pointer set", got, model[10]);

        // R7: save, restore, cancel by repeated START
        m_start(); send(AWR, a0); send(8'hF6, a1); send(8'h12, a2); m_stop(); wq(4);
        check(a1 && !a2, "R7 save acks", {a1, a2}, 2'b10);
        check(save_cnt == 1 && rest_cnt == 0, "R7 one save", save_cnt, 1);
        m_start(); send(AWR, a0); send(8'h0B, a1); m_stop(); wq(4);
        check(rest_cnt == 1 && save_cnt == 1, "R7 one restore", rest_cnt, 1);
        m_start(); send(AWR, a0); send(8'h02, a1); m_start(); send(AWR, a2); m_stop(); wq(4);
        check(save_cnt == 1, "R7 cancelled by restart", save_cnt, 1);

        // R8: busy blocks the address acknowledge
        busy_i = 1'b1;
        m_start(); send(AWR, a0); m_stop();
        check(!a0, "R8 busy nack", a0, 0);
        busy_i = 1'b0;
        m_start(); send(AWR, a0); m_stop();
        check(a0, "R8 idle ack", a0, 1);

        // R9: START and STOP inside a data byte
        base = we_cnt;
        m_start(); send(AWR, a0); send(8'h00, a1); send(8'h05, a2); send_bits(8'hE7, 4);
        m_start(); send(AWR, a3); m_stop();
        m_start(); send(AWR, a0); send(8'h00, a1); send(8'h06, a2); send_bits(8'h18, 3); m_stop();
        check(we_cnt == base, "R9 no partial write", we_cnt, base);
        check(a3, "R9 restart address ack", a3, 1);
        m_start(); send(AWR, a0); send(8'h01, a1); send(8'h05, a2);
        m_start(); send(ARD, a3); recv(1'b1, got);
        check(got == model[5], "R9 reg5 intact", got, model[5]);
        recv(1'b0, got); m_stop();
        check(got == model[6], "R9 reg6 intact", got, model[6]);
        check(sda_oe == 1'b0 && reg_we == 1'b0, "R10 idle after stop", sda_oe, 0);

        summary();
    end
endmodule